// File: doc/BRIEF.md
# Interrupt Pending and Enable Controller

This block collects interrupt requests from up to sixteen peripheral sources into a pending register and combines them with an enable register to drive one level-sensitive interrupt line to the CPU. Both registers sit on a simple single-cycle CPU register bus at two fixed word offsets. A peripheral raises its request line for one or more cycles, and the matching pending bit latches.

Software clears a pending bit by writing a word to the pending register. That word is ANDed into the current contents, so a 0 in a bit position clears that bit and a 1 keeps it. The enable register is plain read/write storage.

The CPU line is high whenever any pending bit is also enabled. It follows any change of either register in the next cycle, so enabling a source whose bit is already pending raises the line at once. Pending bit 3 is the one that collects the DMA completion request.

Top module: `irq_pend_mask_ctrl`

## Requirements
- R1: After reset both registers read as 0 and `cpu_irq` is low.
- R2: A write (`bus_sel`=1, `bus_wr`=1) at offset 0x070 replaces the pending register with (pending AND `bus_wdata[15:0]`): a 0 clears a bit, a 1 keeps it.
- R3: A write at offset 0x074 stores `bus_wdata[15:0]` into the enable register.
- R4: After every clock edge, `cpu_irq` is 1 exactly when (pending AND enable) is nonzero.
- R5: Writing the enable register over bits that are already pending raises `cpu_irq` in the cycle right after that write's clock edge.
- R6: A high `hw_req[i]` at a clock edge sets pending bit i. When an acknowledge write clears the same bit in the same cycle, the set wins.
- R7: A read (`bus_sel`=1, `bus_wr`=0) at 0x070 or 0x074 returns that register in bits 15:0 with bits 31:16 zero, in the same cycle, and changes no state.
- R8: Accesses at any other offset, and bus activity with `bus_sel`=0, change neither register. Reads at any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the I/O window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| hw_req | input | 16 | Peripheral request lines, one per pending bit |
| cpu_irq | output | 1 | Level interrupt to the CPU |

## Verification
A wrong pending or enable bit shows up at the ports in two ways. It reaches `cpu_irq` one edge after it forms, and only while the other register has the matching bit set. It also appears on `bus_rdata` as soon as the register is read. For this reason the bench compares `cpu_irq` against its model after every edge and reads both registers often, so that a corrupted bit hidden behind a zero enable bit is still exposed within a few cycles. The cases given most weight are the same-cycle collision of a request with an acknowledge, and enabling a source over a bit that is already pending.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    // access strobes produced by the address decoder
    typedef struct packed {
        logic wr_pend;
        logic wr_mask;
        logic rd_pend;
        logic rd_mask;
    } irqc_acc_t;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] PEND_OFS = 'h070,
    parameter logic [ADDR_W-1:0] MASK_OFS = 'h074
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output irqc_acc_t         acc
);
    logic hit_pend;
    logic hit_mask;

    always_comb begin
        hit_pend    = sel && (addr == PEND_OFS);
        hit_mask    = sel && (addr == MASK_OFS);
        acc.wr_pend = hit_pend && wr;
        acc.wr_mask = hit_mask && wr;
        acc.rd_pend = hit_pend && !wr;
        acc.rd_mask = hit_mask && !wr;
    end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  irqc_acc_t          acc,
    input  logic [NUM_SRC-1:0] wval,
    input  logic [NUM_SRC-1:0] hw_req,
    output logic [NUM_SRC-1:0] pend_q,
    output logic [NUM_SRC-1:0] mask_q
);
    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] mask;
    } regs_t;

    regs_t st_d;
    regs_t st_q;

    always_comb begin
        st_d = st_q;
        // acknowledge: AND the written word into the pending bits
        if (acc.wr_pend) begin
            st_d.pend = st_q.pend & wval;
        end
        // new requests are merged last so a set beats a same-cycle clear
        st_d.pend = st_d.pend | hw_req;
        if (acc.wr_mask) begin
            st_d.mask = wval;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_q = st_q.pend;
    assign mask_q = st_q.mask;
endmodule

// File: rtl/irqc_level.sv
module irqc_level #(
    parameter int NUM_SRC = 16
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] mask,
    output logic               irq
);
    logic [NUM_SRC-1:0] live;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign live[i] = pend[i] & mask[i];
    end

    assign irq = |live;
endmodule

// File: rtl/irq_pend_mask_ctrl.sv
module irq_pend_mask_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter logic [ADDR_W-1:0] PEND_OFS = 'h070,
    parameter logic [ADDR_W-1:0] MASK_OFS = 'h074
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] hw_req,
    output logic               cpu_irq
);
    // NUM_SRC must stay below DATA_W: the upper write bits are padding
    localparam int PAD_W = DATA_W - NUM_SRC;

    irqc_acc_t          acc;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] mask_q;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];

    irqc_decode #(
        .ADDR_W  (ADDR_W),
        .PEND_OFS(PEND_OFS),
        .MASK_OFS(MASK_OFS)
    ) u_dec (
        .sel (bus_sel),
        .wr  (bus_wr),
        .addr(bus_addr),
        .acc (acc)
    );

    irqc_regs #(
        .NUM_SRC(NUM_SRC)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (acc),
        .wval  (bus_wdata[NUM_SRC-1:0]),
        .hw_req(hw_req),
        .pend_q(pend_q),
        .mask_q(mask_q)
    );

    irqc_level #(
        .NUM_SRC(NUM_SRC)
    ) u_lvl (
        .pend(pend_q),
        .mask(mask_q),
        .irq (cpu_irq)
    );

    // read return: zero-extended register value, no side effects
    always_comb begin
        bus_rdata = '0;
        if (acc.rd_pend) begin
            bus_rdata = {{PAD_W{1'b0}}, pend_q};
        end else if (acc.rd_mask) begin
            bus_rdata = {{PAD_W{1'b0}}, mask_q};
        end
    end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int NUM_SRC = 16,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter logic [ADDR_W-1:0] PEND_OFS = 'h070,
    parameter logic [ADDR_W-1:0] MASK_OFS = 'h074
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_SRC-1:0] hw_req,
    input logic               cpu_irq,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] mask
);
    logic pw;
    logic mw;
    logic quiet;

    assign pw    = bus_sel && bus_wr && (bus_addr == PEND_OFS);
    assign mw    = bus_sel && bus_wr && (bus_addr == MASK_OFS);
    assign quiet = !pw && !mw && (hw_req == '0);

    // R2
    ack_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pw |=> pend == (($past(pend) & $past(bus_wdata[NUM_SRC-1:0])) | $past(hw_req)));

    // R3
    mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mw |=> mask == $past(bus_wdata[NUM_SRC-1:0]));

    // R4
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == ((pend & mask) != '0));

    // R5
    unmask_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mw && ((pend & bus_wdata[NUM_SRC-1:0]) != '0)) |=> cpu_irq);

    // R6
    req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_req != '0) |=> ((pend & $past(hw_req)) == $past(hw_req)));

    // R7
    rd_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NUM_SRC] == '0);

    // R8
    no_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> ($stable(pend) && $stable(mask)));
endmodule

bind irq_pend_mask_ctrl irqc_chk #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .PEND_OFS(PEND_OFS),
    .MASK_OFS(MASK_OFS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .hw_req   (hw_req),
    .cpu_irq  (cpu_irq),
    .pend     (pend_q),
    .mask     (mask_q)
);

// File: tb/sim_irq_pend_mask_ctrl.sv
module sim_irq_pend_mask_ctrl;
    localparam int CLK_P = 10;
    localparam logic [11:0] A_PEND = 12'h070;
    localparam logic [11:0] A_MASK = 12'h074;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] hw_req = '0;
    logic        cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    logic [15:0] m_pend = '0;
    logic [15:0] m_mask = '0;

    always #(CLK_P/2) clk = ~clk;

    irq_pend_mask_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_req(hw_req), .cpu_irq(cpu_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [11:0] a);
        if (a == A_PEND) return {16'h0, m_pend};
        if (a == A_MASK) return {16'h0, m_mask};
        return 32'h0;
    endfunction

    // one bus cycle: drive after a falling edge, check read data before
    // the rising edge, update the model at the edge, check irq after it
    task automatic cyc(input logic s, input logic w, input logic [11:0] a,
                       input logic [31:0] d, input logic [15:0] r, input string tag);
        logic [15:0] np;
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; hw_req = r;
        #1;
        if (s && !w) check(tag, bus_rdata, model_read(a));
        @(posedge clk);
        np = m_pend;
        if (s && w && a == A_PEND) np = np & d[15:0];
        np = np | r;
        if (s && w && a == A_MASK) m_mask = d[15:0];
        m_pend = np;
        @(negedge clk);
        check({tag, "/R4"}, {31'h0, cpu_irq}, {31'h0, (m_pend & m_mask) != 16'h0});
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        cyc(1'b1, 1'b0, a, 32'h0, 16'h0, tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        cyc(1'b1, 1'b1, a, d, 16'h0, tag);
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 irq", {31'h0, cpu_irq}, 32'h0);
        rd(A_PEND, "R1 pend");
        rd(A_MASK, "R1 mask");

        // R6 request pulses set bits; R7 zero-extended read
        cyc(1'b0, 1'b0, 12'h0, 32'h0, 16'h0009, "R6 req");
        rd(A_PEND, "R7 pend");
        rd(A_PEND, "R7 no side effect");

        // R3 mask store, upper write bits dropped; R5 fires at once
        wr(A_MASK, 32'hABCD_0008, "R5 unmask");
        rd(A_MASK, "R3 mask");

        // R2 acknowledge bit 3 (DMA source) with AND semantics
        wr(A_PEND, 32'h0000_FFF7, "R2 ack dma");
        rd(A_PEND, "R2 pend");
        wr(A_PEND, 32'hFFFF_FFFF, "R2 all ones keeps");
        rd(A_PEND, "R2 keep");

        // R6 set beats a same-cycle clear of the same bit
        cyc(1'b1, 1'b1, A_PEND, 32'h0, 16'h0008, "R6 collide");
        rd(A_PEND, "R6 set wins");

        // R8 other offsets and deselected writes leave state alone
        cyc(1'b1, 1'b1, 12'h078, 32'h0, 16'h0, "R8 other wr");
        cyc(1'b0, 1'b1, A_MASK, 32'h0, 16'h0, "R8 no sel");
        cyc(1'b0, 1'b1, A_PEND, 32'h0, 16'h0, "R8 no sel pend");
        rd(12'h078, "R8 other rd");
        rd(A_MASK, "R8 mask kept");
        rd(A_PEND, "R8 pend kept");

        // R4 mask off then on again with the bit still pending
        wr(A_MASK, 32'h0, "R4 mask off");
        wr(A_MASK, 32'hFFFF, "R5 mask all");
        wr(A_PEND, 32'h0, "R2 clear all");
        rd(A_PEND, "R2 zero");

        // mixed random traffic against the model
        for (int i = 0; i < 400; i++) begin
            logic [11:0] a;
            logic [1:0] pick;
            pick = 2'($urandom);
            a = (pick == 0) ? A_PEND : (pick == 1) ? A_MASK :
                (pick == 2) ? 12'h078 : 12'h000;
            cyc(1'($urandom), 1'($urandom), a, $urandom,
                (($urandom % 4) == 0) ? 16'($urandom) : 16'h0, "R2 R3 R6 R7 R8 rand");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule